// File: doc/BRIEF.md
# Four-Neighbour Lookup Cell with Serial Configuration

This block is one tile of a cellular-automaton fabric. It takes one bit from each of its north, south, east and west neighbours. It drives one bit back toward each of them. Each of the four outputs is an arbitrary Boolean function of the four inputs. A private 16-entry lookup table picks that function. The path from neighbour inputs to neighbour outputs has no clock, so a fabric of these tiles settles or oscillates freely.

The tables are loaded over a daisy chain. A 64-bit shift register takes one bit per rising edge of a shift clock. The shift clock and the last bit of the register are passed on to the next tile. The lookup tables do not read the shift register directly. They read a shadow bank of transparent latches, and that bank opens only while the hold input is low. A controller can therefore stream a whole fabric's configuration through the chain while the fabric keeps running on its old functions. It then pulses hold low once to switch every tile to the new functions together.

Top module: `lutcell_top`

## Requirements
- R1: Each output takes its value from the active 64-bit configuration word. Output k returns bit 16k+idx, where idx = {N,S,E,W} with N as the most significant bit, and k = 0 for north, 1 for south, 2 for east and 3 for west.
- R2: The outputs follow a change of the neighbour inputs with no edge on any clock.
- R3: On each rising edge of the shift clock, the register moves up by one position and the serial input enters at bit 0. A bit therefore needs exactly 64 edges to reach bit 63.
- R4: The serial output is bit 63 of the shift register. While a new word is shifted in, the serial output replays the previously held word, most significant bit first.
- R5: While hold is high, shifting leaves every output unchanged for every input combination.
- R6: While hold is low, the shadow bank follows the shift register. After a low pulse of hold, the outputs obey the newly shifted word.
- R7: The forwarded shift clock equals the incoming shift clock at both levels.
- R8: While reset is high, the shadow bank is cleared and every output reads 0. A reset sampled on a rising shift-clock edge clears the shift register, so the serial output reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk_i | input | 1 | Configuration shift clock |
| rst_i | input | 1 | Active-high reset, synchronous for the shift register, level for the shadow bank |
| hold_i | input | 1 | Low opens the shadow latches |
| scan_in_i | input | 1 | Serial configuration input |
| scan_out_o | output | 1 | Serial configuration output to the next tile |
| shift_clk_o | output | 1 | Shift clock forwarded to the next tile |
| in_n | input | 1 | Bit from the north neighbour |
| in_s | input | 1 | Bit from the south neighbour |
| in_e | input | 1 | Bit from the east neighbour |
| in_w | input | 1 | Bit from the west neighbour |
| out_n | output | 1 | Bit toward the north neighbour |
| out_s | output | 1 | Bit toward the south neighbour |
| out_e | output | 1 | Bit toward the east neighbour |
| out_w | output | 1 | Bit toward the west neighbour |

## Verification
A corrupted shift register shows at the serial output. The damaged bit appears within 64 shift edges, at the moment the old word is replayed during the next load. A fault in the shadow bank or the table decode stays hidden until the inputs select the damaged entry. For that reason, every one of the 16 input combinations is applied on all four outputs right after each hold pulse. A shadow bank that leaks while hold is high shows up in the middle of a load, before any pulse, as an output that differs from the old function.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  localparam int NBR_CNT   = 4;
  localparam int SEL_W     = NBR_CNT;
  localparam int LUT_DEPTH = 1 << SEL_W;
  localparam int CFG_W     = NBR_CNT * LUT_DEPTH;

  typedef enum logic [1:0] {
    DIR_N = 2'd0,
    DIR_S = 2'd1,
    DIR_E = 2'd2,
    DIR_W = 2'd3
  } dir_e;

  function automatic int slice_lo(input int k);
    return k * LUT_DEPTH;
  endfunction
endpackage

// File: rtl/lutcell_shift_chain.sv
module lutcell_shift_chain #(
  parameter int WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             sin_i,
  output logic [WIDTH-1:0] q_o,
  output logic             sout_o
);
  logic [WIDTH-1:0] chain_r;

  always_ff @(posedge clk_i) begin
    if (rst_i) chain_r <= '0;
    else       chain_r <= {chain_r[WIDTH-2:0], sin_i};
  end

  assign q_o    = chain_r;
  assign sout_o = chain_r[WIDTH-1];
endmodule

// File: rtl/lutcell_shadow_bank.sv
module lutcell_shadow_bank #(
  parameter int WIDTH = 64
) (
  input  logic             rst_i,
  input  logic             hold_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] shadow_l;

  always_latch begin
    if (rst_i)        shadow_l <= '0;
    else if (!hold_i) shadow_l <= d_i;
  end

  assign q_o = shadow_l;
endmodule

// File: rtl/lutcell_lut.sv
module lutcell_lut #(
  parameter int SEL_W = 4,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic [DEPTH-1:0] table_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             bit_o
);
  assign bit_o = table_i[sel_i];
endmodule

// File: rtl/lutcell_top.sv
module lutcell_top
  import lutcell_pkg::*;
(
  input  logic shift_clk_i,
  input  logic rst_i,
  input  logic hold_i,
  input  logic scan_in_i,
  output logic scan_out_o,
  output logic shift_clk_o,
  input  logic in_n,
  input  logic in_s,
  input  logic in_e,
  input  logic in_w,
  output logic out_n,
  output logic out_s,
  output logic out_e,
  output logic out_w
);
  logic [CFG_W-1:0]   chain_q;
  logic [CFG_W-1:0]   shadow_q;
  logic [SEL_W-1:0]   nbr_idx;
  logic [NBR_CNT-1:0] out_vec;

  assign shift_clk_o = shift_clk_i;
  assign nbr_idx     = {in_n, in_s, in_e, in_w};

  lutcell_shift_chain #(.WIDTH(CFG_W)) chain_i (
    .clk_i  (shift_clk_i),
    .rst_i  (rst_i),
    .sin_i  (scan_in_i),
    .q_o    (chain_q),
    .sout_o (scan_out_o)
  );

  lutcell_shadow_bank #(.WIDTH(CFG_W)) shadow_i (
    .rst_i  (rst_i),
    .hold_i (hold_i),
    .d_i    (chain_q),
    .q_o    (shadow_q)
  );

  for (genvar k = 0; k < NBR_CNT; k++) begin : g_lut
    lutcell_lut #(.SEL_W(SEL_W)) lut_i (
      .table_i (shadow_q[slice_lo(k) +: LUT_DEPTH]),
      .sel_i   (nbr_idx),
      .bit_o   (out_vec[k])
    );
  end

  assign out_n = out_vec[DIR_N];
  assign out_s = out_vec[DIR_S];
  assign out_e = out_vec[DIR_E];
  assign out_w = out_vec[DIR_W];
endmodule

// File: rtl/lutcell_checker.sv
module lutcell_checker #(
  parameter int CFG_W = 64
) (
  input logic             shift_clk_i,
  input logic             rst_i,
  input logic             hold_i,
  input logic             scan_in_i,
  input logic             scan_out_o,
  input logic [CFG_W-1:0] chain_q,
  input logic [CFG_W-1:0] shadow_q,
  input logic [3:0]       outs
);
  assert_bit_enters_R3: assert property (@(posedge shift_clk_i) disable iff (rst_i)
    !rst_i |=> chain_q[0] == $past(scan_in_i));

  assert_serial_tail_R4: assert property (@(posedge shift_clk_i) disable iff (rst_i)
    !rst_i |=> scan_out_o == $past(chain_q[CFG_W-2]));

  always @(negedge shift_clk_i) begin
    if (rst_i) begin
      assert_reset_quiet_R8: assert (outs == 4'b0000);
    end
    if (!rst_i && !hold_i) begin
      assert_open_follows_R6: assert (shadow_q == chain_q);
    end
  end
endmodule

bind lutcell_top lutcell_checker #(.CFG_W(lutcell_pkg::CFG_W)) chk_i (
  .shift_clk_i (shift_clk_i),
  .rst_i       (rst_i),
  .hold_i      (hold_i),
  .scan_in_i   (scan_in_i),
  .scan_out_o  (scan_out_o),
  .chain_q     (chain_q),
  .shadow_q    (shadow_q),
  .outs        ({out_w, out_e, out_s, out_n})
);

// File: tb/lutcell_top_tb_top.sv
module lutcell_top_tb_top;
  logic clk = 1'b0;
  logic shift_clk = 1'b0, rst = 1'b1, hold = 1'b1, scan_in = 1'b0;
  logic in_n = 1'b0, in_s = 1'b0, in_e = 1'b0, in_w = 1'b0;
  logic scan_out, shift_clk_fwd, out_n, out_s, out_e, out_w;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  lutcell_top dut_i (
    .shift_clk_i (shift_clk), .rst_i (rst), .hold_i (hold),
    .scan_in_i (scan_in), .scan_out_o (scan_out), .shift_clk_o (shift_clk_fwd),
    .in_n (in_n), .in_s (in_s), .in_e (in_e), .in_w (in_w),
    .out_n (out_n), .out_s (out_s), .out_e (out_e), .out_w (out_w)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic [63:0] cfg, input int idx);
    return {cfg[48+idx], cfg[32+idx], cfg[16+idx], cfg[idx]};
  endfunction

  task automatic shift_bit(input logic b, output logic seen);
    @(posedge clk);
    scan_in = b;
    seen = scan_out;
    @(negedge clk);
    shift_clk = 1'b1;
    @(posedge clk);
    shift_clk = 1'b0;
  endtask

  task automatic load_cfg(input logic [63:0] cfg, output logic [63:0] seen);
    for (int j = 0; j < 64; j++) begin
      logic s;
      shift_bit(cfg[63-j], s);
      seen[63-j] = s;
    end
  endtask

  task automatic pulse_hold();
    @(posedge clk); hold = 1'b0;
    @(posedge clk); hold = 1'b1;
  endtask

  task automatic sweep(input logic [63:0] cfg, input string req);
    for (int idx = 0; idx < 16; idx++) begin
      @(posedge clk);
      {in_n, in_s, in_e, in_w} = idx[3:0];
      @(negedge clk);
      chk({out_w, out_e, out_s, out_n} == model(cfg, idx), req,
          {60'd0, out_w, out_e, out_s, out_n}, {60'd0, model(cfg, idx)});
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    for (int j = 0; j < 2; j++) begin
      logic s;
      shift_bit(1'b0, s);
    end
    @(negedge clk);
    chk({out_w, out_e, out_s, out_n} == 4'b0, "R8 outputs zero in reset",
        {60'd0, out_w, out_e, out_s, out_n}, 64'd0);
    chk(scan_out == 1'b0, "R8 serial output zero", {63'd0, scan_out}, 64'd0);
    rst = 1'b0;
  endtask

  initial begin
    logic [63:0] cur, nxt, seen;
    logic s;
    void'($urandom(32'd20240611));
    do_reset();
    sweep(64'd0, "R8 all combos zero after reset");

    @(negedge clk);
    chk(shift_clk_fwd == shift_clk, "R7 forward low", {63'd0, shift_clk_fwd}, {63'd0, shift_clk});
    shift_clk = 1'b1; #1;
    chk(shift_clk_fwd == 1'b1, "R7 forward high", {63'd0, shift_clk_fwd}, 64'd1);
    shift_clk = 1'b0; #1;
    chk(shift_clk_fwd == 1'b0, "R7 forward back low", {63'd0, shift_clk_fwd}, 64'd0);
    do_reset();

    // R3: a lone 1 reaches the serial output after exactly 64 edges
    shift_bit(1'b1, s);
    for (int j = 1; j < 63; j++) shift_bit(1'b0, s);
    @(negedge clk);
    chk(scan_out == 1'b0, "R3 bit not out after 63 edges", {63'd0, scan_out}, 64'd0);
    shift_bit(1'b0, s);
    @(negedge clk);
    chk(scan_out == 1'b1, "R3 bit out after 64 edges", {63'd0, scan_out}, 64'd1);
    do_reset();

    // Directed: N=AND, S=OR, E=parity, W=copy of north input
    cur = {16'hFF00, 16'h6996, 16'hFFFE, 16'h8000};
    load_cfg(cur, seen);
    chk(seen == 64'd0, "R4 replay after reset", seen, 64'd0);
    sweep(64'd0, "R5 no change before hold pulse");
    pulse_hold();
    sweep(cur, "R1 R2 directed functions");

    for (int r = 0; r < 6; r++) begin
      nxt = {$urandom(), $urandom()};
      load_cfg(nxt, seen);
      chk(seen == cur, "R4 serial replay of old word", seen, cur);
      sweep(cur, "R5 old function held while shifting");
      pulse_hold();
      sweep(nxt, "R1 R6 new function after pulse");
      cur = nxt;
    end

    // Transparent load with hold low throughout
    nxt = 64'hA5A5_0F0F_3C3C_FFFF;
    @(posedge clk); hold = 1'b0;
    load_cfg(nxt, seen);
    sweep(nxt, "R6 open latches follow shifting");
    @(posedge clk); hold = 1'b1;
    chk(seen == cur, "R4 replay during transparent load", seen, cur);

    // Reset wipes the active function
    @(posedge clk); rst = 1'b1;
    @(negedge clk);
    chk({out_w, out_e, out_s, out_n} == 4'b0, "R8 reset clears live tables",
        {60'd0, out_w, out_e, out_s, out_n}, 64'd0);
    do_reset();
    sweep(64'd0, "R8 cleared after reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule